// File: doc/BRIEF.md
# Timed-Access Unlock Guard

This block stands between a register write bus and a group of protected control bits. Those bits may only be written right after software has written a two-byte unlock key into one dedicated key register. The guard sees every bus write as an address, a data byte and a strobe. It also sees a machine-cycle tick. From these it produces a qualifier that a protected register combines with its own write decode. It also reports whether a write window is open.

The unlock runs in three steps. The first key byte arms the guard. The second key byte must follow within a short number of machine cycles, and it opens a write window. That window stays open for a bounded number of machine cycles, or until one protected write has been accepted, whichever comes first. If anything delays a step, such as an interrupt service routine running between the writes, the attempt times out and software must start over. The protected registers and the interrupt logic are outside this block. The bus marks a write to a protected register through a select input.

Top module: `ta_guard`

## Requirements
- R1: From idle, a write of 0xAA to the key register at address 0xC7 arms the guard. Nothing else leaves idle, and the window stays closed.
- R2: While armed, a key write of 0x55 that follows the 0xAA with at most two cycle ticks between them opens the window. `win_open` reads 1 from the clock edge that takes that write.
- R3: If the third cycle tick after the 0xAA arrives before the 0x55, the guard returns to idle, and a later 0x55 does not open the window.
- R4: While armed, a key write of any value other than 0x55 (0xAA included) returns the guard to idle.
- R5: `prot_wr_ok` is 1 in the same cycle as a write with `prot_sel` high while the window is open, and 0 in every other case.
- R6: Once a protected write has been accepted, the window is closed from the next clock edge on, so a second protected write is refused.
- R7: The window closes on the third cycle tick after it opened. A protected write that comes after at most two ticks is accepted.
- R8: While the window is open, a key write of 0xAA closes the window and re-arms the sequence without extending the window. A key write of any other value closes the window and returns to idle.
- R9: Writes to addresses other than the key register, apart from the protected write that R6 covers, leave the sequencer unchanged.
- R10: Synchronous active-low reset puts the guard in idle with the window closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_tick | input | 1 | One-clock pulse per machine cycle |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| prot_sel | input | 1 | The current write targets a protected register |
| prot_wr_ok | output | 1 | Qualifier that allows the protected write in this cycle |
| win_open | output | 1 | The write window is open |

## Verification
The bench builds the guard with its default values: a key gap limit and a window limit of three ticks each, an 8-bit address and 8-bit data. With these small limits, a sweep of every tick delay from zero to four before the second key byte, crossed with every delay from zero to four before the protected write, covers both timeout edges from each side. Directed sequences then cover a wrong second byte, re-arming while the window is open, a write that targets no key, the single-write close and a reset taken mid-window.

// File: rtl/ta_pkg.sv
// Package ta_pkg
// Shared types of the timed-access guard: the sequencer state encoding.
// Assumes nothing beyond a two-bit state being sufficient.
package ta_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_OPEN  = 2'd2
    } ta_state_t;
endpackage

// File: rtl/ta_key_decode.sv
// Module ta_key_decode
// Recognises a bus write aimed at the key register and classifies its data
// as first key byte, second key byte or neither.
// Assumes one write per clock while wr_en is high.
module ta_key_decode #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_wr,
    output logic              is_first,
    output logic              is_second
);
    // Address match qualified by the strobe, data compares per key byte.
    always_comb begin
        key_wr    = wr_en && (wr_addr == KEY_ADDR);
        is_first  = (wr_data == KEY_FIRST);
        is_second = (wr_data == KEY_SECOND);
    end
endmodule

// File: rtl/ta_cycle_timer.sv
// Module ta_cycle_timer
// Counts machine-cycle ticks from a restart. It flags expiry on the tick
// that reaches the programmed limit (limit_m1 is the limit minus one).
// Assumes restart is asserted whenever the limit selection changes.
module ta_cycle_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit_m1,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Expiry is flagged combinationally on the last counted tick.
    always_comb expire = tick && (cnt == limit_m1);

    // Counter: cleared on reset or restart, advanced on each live tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (tick && !expire)
            cnt <= cnt + 1'b1;
    end

    // R7 / R3 deadlines: the count never passes the selected limit.
    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit_m1);
endmodule

// File: rtl/ta_sequencer.sv
// Module ta_sequencer
// Three-state unlock machine (idle, armed, open). It owns a shared tick
// timer whose limit follows the state, and it drives the protected-write
// qualifier. A key write takes precedence over a tick in the same cycle.
// Assumes the key decode and protected select are valid only with wr_en.
module ta_sequencer #(
    parameter int GAP_CYC = 3,
    parameter int WIN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_tick,
    input  logic wr_en,
    input  logic prot_sel,
    input  logic key_wr,
    input  logic is_first,
    input  logic is_second,
    output logic prot_wr_ok,
    output logic win_open
);
    import ta_pkg::*;

    localparam int MAX_CYC = (GAP_CYC > WIN_CYC) ? GAP_CYC : WIN_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] GAP_M1 = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] WIN_M1 = CNT_W'(WIN_CYC - 1);

    ta_state_t        state, state_nx;
    logic             expire;
    logic             restart;
    logic [CNT_W-1:0] limit_m1;
    logic             prot_acc;

    // A protected write is accepted only while the window is open.
    always_comb begin
        prot_acc   = wr_en && prot_sel && (state == S_OPEN);
        prot_wr_ok = prot_acc;
        win_open   = (state == S_OPEN);
    end

    // Timer limit follows the phase: window length when open, else key gap.
    always_comb limit_m1 = (state == S_OPEN) ? WIN_M1 : GAP_M1;

    // Next-state decision; key writes outrank ticks and accepted writes.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (key_wr && is_first)
                    state_nx = S_ARMED;
            end
            S_ARMED: begin
                if (key_wr)
                    state_nx = is_second ? S_OPEN : S_IDLE;
                else if (expire)
                    state_nx = S_IDLE;
            end
            S_OPEN: begin
                if (key_wr)
                    state_nx = is_first ? S_ARMED : S_IDLE;
                else if (prot_acc || expire)
                    state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Every state change starts a fresh count for the new phase.
    always_comb restart = (state_nx != state);

    ta_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .tick     (cyc_tick),
        .limit_m1 (limit_m1),
        .expire   (expire)
    );

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // R5: the qualifier never appears without an open window.
    a_r5_ok_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr_ok |-> win_open);
    // R6: one accepted protected write closes the window.
    a_r6_close_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr_ok |=> !win_open);
    // R2: the window only opens from the armed state.
    a_r2_open_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(state == S_ARMED));
    // R4: a wrong key byte while armed drops back to idle.
    a_r4_bad_key_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && key_wr && !is_second) |=> (state == S_IDLE));
endmodule

// File: rtl/ta_guard.sv
// Module ta_guard
// Top of the timed-access unlock guard: key decode plus sequencer.
// Assumes a one-clock cyc_tick per machine cycle and single-clock writes.
module ta_guard #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hC7,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
    parameter int GAP_CYC = 3,
    parameter int WIN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prot_sel,
    output logic              prot_wr_ok,
    output logic              win_open
);
    logic key_wr, is_first, is_second;

    ta_key_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .KEY_ADDR   (KEY_ADDR),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .key_wr    (key_wr),
        .is_first  (is_first),
        .is_second (is_second)
    );

    ta_sequencer #(
        .GAP_CYC (GAP_CYC),
        .WIN_CYC (WIN_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_tick   (cyc_tick),
        .wr_en      (wr_en),
        .prot_sel   (prot_sel),
        .key_wr     (key_wr),
        .is_first   (is_first),
        .is_second  (is_second),
        .prot_wr_ok (prot_wr_ok),
        .win_open   (win_open)
    );
endmodule

// File: tb/ta_guard_bench.sv
`timescale 1ns/1ps
// Bench for ta_guard: tick-delay sweep plus directed sequences.
module ta_guard_bench;
    localparam int GAP = 3;
    localparam int WIN = 3;
    localparam logic [7:0] KADDR = 8'hC7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       prot_sel = 1'b0;
    logic       prot_wr_ok;
    logic       win_open;

    int checks = 0;
    int errors = 0;
    logic last_ok;

    always #2.5 clk = ~clk;

    ta_guard u_ta_guard (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .prot_sel(prot_sel),
        .prot_wr_ok(prot_wr_ok), .win_open(win_open)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle, then an idle cycle; last_ok holds the comb qualifier.
    task automatic bus(input logic t, input logic we, input logic [7:0] a,
                       input logic [7:0] d, input logic p);
        @(negedge clk);
        cyc_tick = t; wr_en = we; wr_addr = a; wr_data = d; prot_sel = p;
        #1 last_ok = prot_wr_ok;
        @(negedge clk);
        cyc_tick = 1'b0; wr_en = 1'b0; prot_sel = 1'b0;
        wr_addr = '0; wr_data = '0;
    endtask

    task automatic tick();            bus(1'b1, 1'b0, 8'h00, 8'h00, 1'b0); endtask
    task automatic kwr(input logic [7:0] d); bus(1'b0, 1'b1, KADDR, d, 1'b0); endtask
    task automatic pwr();             bus(1'b0, 1'b1, 8'h20, 8'hFF, 1'b1); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset closed", win_open, 1'b0);
        #1 chk("R10 reset no qualifier", prot_wr_ok, 1'b0);
        rst_n = 1'b1;
        pwr();
        chk("R5 write while idle refused", last_ok, 1'b0);

        // Sweep over key gap g and window delay w (R2 R3 R5 R6 R7).
        for (int g = 0; g <= 4; g++) begin
            for (int w = 0; w <= 4; w++) begin
                kwr(8'h00);
                kwr(8'hAA);
                chk("R1 armed keeps window shut", win_open, 1'b0);
                for (int i = 0; i < g; i++) tick();
                kwr(8'h55);
                chk(g < GAP ? "R2 opens within gap" : "R3 gap timeout",
                    win_open, g < GAP);
                for (int i = 0; i < w; i++) tick();
                pwr();
                chk("R7 window length", last_ok, (g < GAP) && (w < WIN));
                chk("R6 closed after write", win_open, 1'b0);
            end
        end

        // R4: wrong second byte, and a repeated AA, both drop to idle.
        kwr(8'hAA); kwr(8'h12); kwr(8'h55);
        chk("R4 wrong byte aborts", win_open, 1'b0);
        kwr(8'hAA); kwr(8'hAA); kwr(8'h55);
        chk("R4 repeated AA aborts", win_open, 1'b0);

        // R9: foreign writes do not disturb the armed state.
        kwr(8'hAA);
        bus(1'b0, 1'b1, 8'hC6, 8'h55, 1'b0);
        pwr();
        chk("R5 write while armed refused", last_ok, 1'b0);
        kwr(8'h55);
        chk("R9 foreign writes ignored", win_open, 1'b1);
        bus(1'b0, 1'b1, 8'h10, 8'hAA, 1'b0);
        chk("R9 open kept", win_open, 1'b1);

        // R6: second protected write refused.
        pwr();
        chk("R6 first accepted", last_ok, 1'b1);
        pwr();
        chk("R6 second refused", last_ok, 1'b0);

        // R8: AA while open re-arms without extending the window.
        kwr(8'hAA); kwr(8'h55); tick(); tick();
        kwr(8'hAA);
        chk("R8 AA closes window", win_open, 1'b0);
        pwr();
        chk("R8 rearmed refuses write", last_ok, 1'b0);
        kwr(8'h55);
        chk("R8 rearm opens again", win_open, 1'b1);
        tick(); tick(); tick();
        chk("R7 expires on third tick", win_open, 1'b0);
        kwr(8'hAA); kwr(8'h55); kwr(8'h3C);
        chk("R8 other key closes", win_open, 1'b0);
        kwr(8'h55);
        chk("R8 other key goes idle", win_open, 1'b0);

        // R10: reset mid-window.
        kwr(8'hAA); kwr(8'h55);
        chk("R10 open before reset", win_open, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 reset closes", win_open, 1'b0);
        pwr();
        chk("R10 write after reset refused", last_ok, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule